// File: doc/BRIEF.md
# Address Region Decoder

This block sits on one processor's data port and turns each request into a single access on a downstream memory port. Bits 31:24 of the address choose the target: boot ROM, main RAM, working RAM, tightly-coupled instruction memory (TCM) with its mirror, or the I/O space. Working RAM has two targets. One is a bank private to this processor. The other is a shared bank whose size is programmable. The block hands the downstream port a region code and an offset that is already masked. The memory arrays and I/O registers sit behind that port.

The block places write data on the correct byte lanes and drives the matching byte enables. On a read it aligns the returned word for 8-, 16- and 32-bit accesses, and it reports the wait count of the access. Some accesses cannot be served: an unmapped region, a write to ROM, an absent ROM, or a TCM address past the programmed bound. For these the block issues no downstream request and pulses `err` for one cycle. It then answers the access itself. The answer is zero, or a fixed illegal opcode when the access is an instruction fetch.

The block takes one access at a time. All three streams use valid/ready:

- **Request stream.** A request is taken only in a cycle where `req_valid` and `req_ready` are both high.
- **Downstream port.** `mem_valid` stays high, with every `mem_*` field held stable, until a cycle with `mem_ready` high.
- **Read data.** `rd_valid` and `rd_data` are accepted in any cycle while the block waits for read data.
- **Response.** `rsp_valid` stays high, with `rsp_data` and `rsp_wait` held, until a cycle with `rsp_ready` high.

Top module: `addr_region_decoder`

## Requirements
- R1: The region comes from addr[31:24]: 0x00 and 0x01 TCM, 0x02 main RAM, 0x03 working RAM, 0x04 I/O, 0xFF boot ROM. `mem_region` encodes 1 ROM, 2 main RAM, 3 private working RAM, 4 shared working RAM, 5 TCM, 6 I/O, and never 0 while `mem_valid` is high. The I/O offset is addr & 0x00FFFFFF.
- R2: The main-RAM offset is addr & (2^RAM_AW - 1), so the RAM repeats across its whole region. With the default RAM_AW=22 the mask is 0x3FFFFF. The ROM offset is addr & 0xFFF, from the default ROM_AW=12.
- R3: A working-RAM access goes to the private bank (code 3) with offset addr & 0xFFFF when either holds:
  - the address is at or above PRIV_BASE (0x03800000), or
  - the shared size is zero.

  Otherwise it goes to the shared bank (code 4) with offset addr & (size - 1).
- R4: The shared size register resets to SHARED_RESET (0x8000). A cycle with `cfg_wr` high loads it from `cfg_size`. A request taken in that same cycle is decoded with the old size.
- R5: A TCM or TCM-mirror access is served (code 5, offset addr & 0x7FFF) only when addr < 512 << `tcm_vsize`. Otherwise it makes no downstream request: a write is dropped and a read returns 0.
- R6: These accesses make no downstream request:
  - an unmapped region,
  - a write to ROM,
  - any access to an absent ROM,
  - a TCM access out of bound.

  For any of them `err` is high for exactly the one cycle after acceptance, together with `rsp_valid`. A fetch read (`req_fetch`=1) returns 0xE710B710; any other access returns 0.
- R7: Read alignment uses `req_size` (0 byte, 1 half, 2 or 3 word) and the returned word `rd_data`:
  - word: `rd_data` rotated right by 8 × addr[1:0];
  - half: the half-word lane picked by addr[1], zero-extended, then rotated right by 8 × addr[0];
  - byte: the byte lane picked by addr[1:0], zero-extended.
- R8: Byte lanes for each size:
  - byte: `mem_be` = 1 << addr[1:0], with the low data byte copied to all four lanes;
  - half: `mem_be` = 0011 when addr[1]=0 and 1100 when addr[1]=1, with the low half-word copied to both halves;
  - word: `mem_be` = 1111, data unchanged.
- R9: `rsp_wait` is 2 for every read and 1 for every write, including accesses that fail.
- R10: `req_ready` is high only while no access is in progress. `mem_valid` with its fields, and `rsp_valid` with its data, are held until their ready is seen. A read goes on to wait for `rd_valid` after the `mem_ready` handshake. A write goes straight to its response.
- R11: After reset, `req_ready`=1, `mem_valid`=0, `rsp_valid`=0 and `err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken this cycle if valid |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 half, 2/3 word |
| req_fetch | input | 1 | Read is an instruction fetch |
| req_wdata | input | 32 | Write data, right-justified |
| cfg_wr | input | 1 | Load shared working-RAM size |
| cfg_size | input | 24 | New shared size in bytes (power of two or zero) |
| tcm_vsize | input | 5 | TCM bound shift: limit = 512 << value |
| mem_valid | output | 1 | Downstream access offered |
| mem_ready | input | 1 | Downstream access taken |
| mem_region | output | 3 | Target region code |
| mem_offset | output | 24 | Masked offset within the region |
| mem_write | output | 1 | Downstream write |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| rd_valid | input | 1 | Read word returned |
| rd_data | input | 32 | Word containing the addressed bytes |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 32 | Aligned read data, or 0 for writes |
| rsp_wait | output | 2 | Wait cycles of the access |
| err | output | 1 | One-cycle pulse for a failed access |

## Verification
Two things can happen in the same cycle: a new shared size is loaded, and a working-RAM request is decoded. The bench asserts `cfg_wr` with size 0 in the very cycle that a request to 0x03019234 is taken. That request must still reach the shared bank at offset 0x1234 under the old 0x8000 size. An identical request that follows must reach the private bank at offset 0x9234. The second pairing is the error pulse with the self-generated response: the bench holds `rsp_ready` low and checks that `err` rises together with `rsp_valid` and drops one cycle later, while the response stays.

// File: rtl/ard_pkg.sv
package ard_pkg;
  localparam int OFF_W = 24;
  localparam logic [31:0] ILLEGAL_OP = 32'hE710B710;

  typedef enum logic [2:0] {
    REG_NONE  = 3'd0,
    REG_ROM   = 3'd1,
    REG_MRAM  = 3'd2,
    REG_WPRIV = 3'd3,
    REG_WSHR  = 3'd4,
    REG_TCM   = 3'd5,
    REG_IO    = 3'd6
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_RD   = 2'd2,
    ST_RSP  = 2'd3
  } state_e;

  function automatic logic [31:0] ror32(input logic [31:0] v, input logic [4:0] s);
    logic [63:0] t;
    t = {v, v} >> s;
    return t[31:0];
  endfunction
endpackage

// File: rtl/ard_region_map.sv
module ard_region_map
  import ard_pkg::*;
#(
  parameter int          RAM_AW      = 22,
  parameter int          PRIV_AW     = 16,
  parameter int          TCM_AW      = 15,
  parameter int          ROM_AW      = 12,
  parameter logic [31:0] PRIV_BASE   = 32'h0380_0000,
  parameter bit          ROM_PRESENT = 1'b1,
  parameter logic [7:0]  TCM_B       = 8'h00,
  parameter logic [7:0]  TCM_MIR_B   = 8'h01,
  parameter logic [7:0]  MRAM_B      = 8'h02,
  parameter logic [7:0]  WRAM_B      = 8'h03,
  parameter logic [7:0]  IO_B        = 8'h04,
  parameter logic [7:0]  ROM_B       = 8'hFF
) (
  input  logic [31:0]      addr,
  input  logic             write,
  input  logic [OFF_W-1:0] shared_size,
  input  logic [4:0]       tcm_vsize,
  output region_e          region,
  output logic [OFF_W-1:0] offset,
  output logic             hit
);
  localparam logic [OFF_W-1:0] RAM_MASK  = OFF_W'((64'd1 << RAM_AW) - 64'd1);
  localparam logic [OFF_W-1:0] PRIV_MASK = OFF_W'((64'd1 << PRIV_AW) - 64'd1);
  localparam logic [OFF_W-1:0] TCM_MASK  = OFF_W'((64'd1 << TCM_AW) - 64'd1);
  localparam logic [OFF_W-1:0] ROM_MASK  = OFF_W'((64'd1 << ROM_AW) - 64'd1);

  logic [OFF_W-1:0] low;
  logic             tcm_in_bound;

  assign low          = addr[OFF_W-1:0];
  assign tcm_in_bound = {32'd0, addr} < (64'd512 << tcm_vsize);

  always_comb begin
    region = REG_NONE;
    offset = '0;
    case (addr[31:24])
      TCM_B, TCM_MIR_B: begin
        if (tcm_in_bound) begin
          region = REG_TCM;
          offset = low & TCM_MASK;
        end
      end
      MRAM_B: begin
        region = REG_MRAM;
        offset = low & RAM_MASK;
      end
      WRAM_B: begin
        if (addr >= PRIV_BASE || shared_size == '0) begin
          region = REG_WPRIV;
          offset = low & PRIV_MASK;
        end else begin
          region = REG_WSHR;
          offset = low & (shared_size - 1'b1);
        end
      end
      IO_B: begin
        region = REG_IO;
        offset = low;
      end
      ROM_B: begin
        if (ROM_PRESENT && !write) begin
          region = REG_ROM;
          offset = low & ROM_MASK;
        end
      end
      default: ;
    endcase
  end

  assign hit = (region != REG_NONE);
endmodule

// File: rtl/ard_wr_lanes.sv
module ard_wr_lanes (
  input  logic [1:0]  size,
  input  logic [1:0]  alo,
  input  logic [31:0] wdata,
  output logic [3:0]  be,
  output logic [31:0] lane_data
);
  always_comb begin
    case (size)
      2'd0: begin
        be        = 4'b0001 << alo;
        lane_data = {4{wdata[7:0]}};
      end
      2'd1: begin
        be        = alo[1] ? 4'b1100 : 4'b0011;
        lane_data = {2{wdata[15:0]}};
      end
      default: begin
        be        = 4'b1111;
        lane_data = wdata;
      end
    endcase
  end
endmodule

// File: rtl/ard_rd_align.sv
module ard_rd_align
  import ard_pkg::*;
(
  input  logic [1:0]  size,
  input  logic [1:0]  alo,
  input  logic [31:0] rdata,
  output logic [31:0] aligned
);
  logic [31:0] byte_sh;
  logic [15:0] half;

  assign byte_sh = rdata >> {alo, 3'b000};
  assign half    = alo[1] ? rdata[31:16] : rdata[15:0];

  always_comb begin
    case (size)
      2'd0:    aligned = {24'd0, byte_sh[7:0]};
      2'd1:    aligned = ror32({16'd0, half}, {1'b0, alo[0], 3'b000});
      default: aligned = ror32(rdata, {alo, 3'b000});
    endcase
  end
endmodule

// File: rtl/addr_region_decoder.sv
module addr_region_decoder
  import ard_pkg::*;
#(
  parameter int               RAM_AW       = 22,
  parameter int               PRIV_AW      = 16,
  parameter int               TCM_AW       = 15,
  parameter int               ROM_AW       = 12,
  parameter logic [31:0]      PRIV_BASE    = 32'h0380_0000,
  parameter logic [OFF_W-1:0] SHARED_RESET = 24'h00_8000,
  parameter bit               ROM_PRESENT  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_addr,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic             req_fetch,
  input  logic [31:0]      req_wdata,
  input  logic             cfg_wr,
  input  logic [OFF_W-1:0] cfg_size,
  input  logic [4:0]       tcm_vsize,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [2:0]       mem_region,
  output logic [OFF_W-1:0] mem_offset,
  output logic             mem_write,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic             rd_valid,
  input  logic [31:0]      rd_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [31:0]      rsp_data,
  output logic [1:0]       rsp_wait,
  output logic             err
);
  state_e           state;
  logic [OFF_W-1:0] shared_q;
  region_e          dec_region, region_q;
  logic [OFF_W-1:0] dec_offset, offset_q;
  logic             dec_hit;
  logic [3:0]       dec_be, be_q;
  logic [31:0]      dec_wdata, wdata_q;
  logic [31:0]      rd_aligned, rsp_q;
  logic             write_q, err_q;
  logic [1:0]       size_q, alo_q;
  logic             take;

  ard_region_map #(
    .RAM_AW(RAM_AW), .PRIV_AW(PRIV_AW), .TCM_AW(TCM_AW), .ROM_AW(ROM_AW),
    .PRIV_BASE(PRIV_BASE), .ROM_PRESENT(ROM_PRESENT)
  ) u_map (
    .addr(req_addr), .write(req_write), .shared_size(shared_q),
    .tcm_vsize(tcm_vsize), .region(dec_region), .offset(dec_offset), .hit(dec_hit)
  );

  ard_wr_lanes u_wl (
    .size(req_size), .alo(req_addr[1:0]), .wdata(req_wdata),
    .be(dec_be), .lane_data(dec_wdata)
  );

  ard_rd_align u_ra (
    .size(size_q), .alo(alo_q), .rdata(rd_data), .aligned(rd_aligned)
  );

  assign take = (state == ST_IDLE) && req_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shared_q <= SHARED_RESET;
    else if (cfg_wr) shared_q <= cfg_size;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      region_q <= REG_NONE;
      offset_q <= '0;
      be_q     <= '0;
      wdata_q  <= '0;
      write_q  <= 1'b0;
      size_q   <= '0;
      alo_q    <= '0;
      rsp_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state)
        ST_IDLE: if (take) begin
          region_q <= dec_region;
          offset_q <= dec_offset;
          be_q     <= dec_be;
          wdata_q  <= dec_wdata;
          write_q  <= req_write;
          size_q   <= req_size;
          alo_q    <= req_addr[1:0];
          if (dec_hit) begin
            rsp_q <= '0;
            state <= ST_MEM;
          end else begin
            rsp_q <= (!req_write && req_fetch) ? ILLEGAL_OP : 32'd0;
            err_q <= 1'b1;
            state <= ST_RSP;
          end
        end
        ST_MEM: if (mem_ready) state <= write_q ? ST_RSP : ST_RD;
        ST_RD: if (rd_valid) begin
          rsp_q <= rd_aligned;
          state <= ST_RSP;
        end
        ST_RSP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign mem_valid  = (state == ST_MEM);
  assign mem_region = region_q;
  assign mem_offset = offset_q;
  assign mem_write  = write_q;
  assign mem_be     = be_q;
  assign mem_wdata  = wdata_q;
  assign rsp_valid  = (state == ST_RSP);
  assign rsp_data   = rsp_q;
  assign rsp_wait   = write_q ? 2'd1 : 2'd2;
  assign err        = err_q;
endmodule

// File: rtl/ard_checker.sv
module ard_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [2:0]  mem_region,
  input logic [23:0] mem_offset,
  input logic        mem_write,
  input logic [3:0]  mem_be,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_data,
  input logic [1:0]  rsp_wait,
  input logic        err
);
  assert_idle_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_valid && !rsp_valid));

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_offset) && $stable(mem_region)));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_wait)));

  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  assert_err_with_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (rsp_valid && !mem_valid));

  assert_region_named_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_region != 3'd0));

  assert_lane_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                                  $countones(mem_be) == 4));

  assert_wait_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_wait == (mem_write ? 2'd1 : 2'd2)));
endmodule

bind addr_region_decoder ard_checker u_chk (.*);

// File: tb/addr_region_decoder_test.sv
`timescale 1ns/1ps
module addr_region_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic        cfg_wr = 1'b0;
  logic [23:0] cfg_size = '0;
  logic [4:0]  tcm_vsize = 5'd5;
  logic        mem_ready = 1'b0, rd_valid = 1'b0, rsp_ready = 1'b0;
  logic [31:0] rd_data = '0;
  logic        req_ready, mem_valid, mem_write, rsp_valid, err;
  logic [2:0]  mem_region;
  logic [23:0] mem_offset;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, rsp_data;
  logic [1:0]  rsp_wait;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  addr_region_decoder uut (.*);

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic acc(input string tag, input logic [31:0] a, input bit wr,
                     input logic [1:0] sz, input bit fe, input logic [31:0] wd,
                     input logic [31:0] rword, input bit cw, input logic [23:0] cs,
                     input bit exp_mem, input logic [2:0] ereg, input logic [23:0] eoff,
                     input logic [3:0] ebe, input logic [31:0] ewd, input logic [31:0] edata);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_size = sz; req_fetch = fe;
    req_wdata = wd; cfg_wr = cw; cfg_size = cs;
    @(negedge clk);
    req_valid = 1'b0; cfg_wr = 1'b0;
    if (exp_mem) begin
      chk(tag, "mem_valid", 32'(mem_valid), 32'd1);
      chk(tag, "err", 32'(err), 32'd0);
      chk(tag, "region", 32'(mem_region), 32'(ereg));
      chk(tag, "offset", 32'(mem_offset), 32'(eoff));
      chk(tag, "be", 32'(mem_be), 32'(ebe));
      chk(tag, "mem_write", 32'(mem_write), 32'(wr));
      if (wr) chk(tag, "wdata", mem_wdata, ewd);
      @(negedge clk);
      chk("R10", "mem held", 32'(mem_valid), 32'd1);
      chk("R10", "offset held", 32'(mem_offset), 32'(eoff));
      mem_ready = 1'b1;
      @(negedge clk);
      mem_ready = 1'b0;
      if (!wr) begin
        chk("R10", "mem released", 32'(mem_valid), 32'd0);
        rd_valid = 1'b1; rd_data = rword;
        @(negedge clk);
        rd_valid = 1'b0;
      end
    end else begin
      chk(tag, "no mem request", 32'(mem_valid), 32'd0);
      chk("R6", "err raised", 32'(err), 32'd1);
    end
    chk("R10", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(tag, "rsp_data", rsp_data, edata);
    chk("R9", "rsp_wait", 32'(rsp_wait), wr ? 32'd1 : 32'd2);
    @(negedge clk);
    chk("R6", "err one cycle", 32'(err), 32'd0);
    chk("R10", "rsp held", 32'(rsp_valid), 32'd1);
    chk("R10", "rsp data held", rsp_data, edata);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R10", "rsp done", 32'(rsp_valid), 32'd0);
    chk("R10", "ready again", 32'(req_ready), 32'd1);
  endtask

  task automatic t_reset;
    chk("R11", "req_ready", 32'(req_ready), 32'd1);
    chk("R11", "mem_valid", 32'(mem_valid), 32'd0);
    chk("R11", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R11", "err", 32'(err), 32'd0);
  endtask

  task automatic t_main_ram;
    acc("R2", 32'h0240_1238, 0, 2'd2, 0, 0, 32'h1122_3344, 0, 0, 1, 3'd2, 24'h00_1238, 4'hF, 0, 32'h1122_3344);
    acc("R7", 32'h0200_0011, 0, 2'd2, 0, 0, 32'hAABB_CCDD, 0, 0, 1, 3'd2, 24'h00_0011, 4'hF, 0, 32'hDDAA_BBCC);
    acc("R7", 32'h0200_0003, 0, 2'd1, 0, 0, 32'hAABB_CCDD, 0, 0, 1, 3'd2, 24'h00_0003, 4'hC, 0, 32'hBB00_00AA);
    acc("R7", 32'h0200_0002, 0, 2'd0, 0, 0, 32'hAABB_CCDD, 0, 0, 1, 3'd2, 24'h00_0002, 4'h4, 0, 32'h0000_00BB);
    acc("R8", 32'h0200_0001, 1, 2'd0, 0, 32'h0000_005A, 0, 0, 0, 1, 3'd2, 24'h00_0001, 4'h2, 32'h5A5A_5A5A, 0);
  endtask

  task automatic t_io;
    acc("R8", 32'h0400_0206, 1, 2'd1, 0, 32'h0000_BEEF, 0, 0, 0, 1, 3'd6, 24'h00_0206, 4'hC, 32'hBEEF_BEEF, 0);
    acc("R1", 32'h0412_3454, 1, 2'd2, 0, 32'h0102_0304, 0, 0, 0, 1, 3'd6, 24'h12_3454, 4'hF, 32'h0102_0304, 0);
  endtask

  task automatic t_wram;
    // R4: size load and decode in the same cycle uses the old 0x8000 size
    acc("R4", 32'h0301_9234, 0, 2'd2, 0, 0, 32'h0000_0077, 1, 24'h0, 1, 3'd4, 24'h00_1234, 4'hF, 0, 32'h0000_0077);
    acc("R3", 32'h0301_9234, 0, 2'd2, 0, 0, 32'h0000_0088, 0, 0, 1, 3'd3, 24'h00_9234, 4'hF, 0, 32'h0000_0088);
    @(negedge clk); cfg_wr = 1'b1; cfg_size = 24'h00_4000;
    @(negedge clk); cfg_wr = 1'b0;
    acc("R3", 32'h0380_0010, 1, 2'd2, 0, 32'hCAFE_F00D, 0, 0, 0, 1, 3'd3, 24'h00_0010, 4'hF, 32'hCAFE_F00D, 0);
    acc("R3", 32'h0300_5678, 1, 2'd2, 0, 32'h1234_5678, 0, 0, 0, 1, 3'd4, 24'h00_1678, 4'hF, 32'h1234_5678, 0);
  endtask

  task automatic t_tcm;
    tcm_vsize = 5'd5;
    acc("R5", 32'h0000_3FFC, 1, 2'd2, 0, 32'h0BAD_CAFE, 0, 0, 0, 1, 3'd5, 24'h00_3FFC, 4'hF, 32'h0BAD_CAFE, 0);
    acc("R5", 32'h0000_4000, 1, 2'd2, 0, 32'h0BAD_CAFE, 0, 0, 0, 0, 3'd0, 0, 0, 0, 0);
    acc("R5", 32'h0000_4000, 0, 2'd2, 0, 0, 0, 0, 0, 0, 3'd0, 0, 0, 0, 0);
    acc("R5", 32'h0100_8010, 0, 2'd2, 0, 0, 0, 0, 0, 0, 3'd0, 0, 0, 0, 0);
    tcm_vsize = 5'd16;
    acc("R5", 32'h0100_8010, 0, 2'd2, 0, 0, 32'h5555_AAAA, 0, 0, 1, 3'd5, 24'h00_0010, 4'hF, 0, 32'h5555_AAAA);
  endtask

  task automatic t_unmapped;
    acc("R6", 32'h0800_0000, 0, 2'd2, 1, 0, 0, 0, 0, 0, 3'd0, 0, 0, 0, 32'hE710_B710);
    acc("R6", 32'h0800_0004, 0, 2'd2, 0, 0, 0, 0, 0, 0, 3'd0, 0, 0, 0, 32'h0);
    acc("R6", 32'h0900_0000, 1, 2'd2, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 3'd0, 0, 0, 0, 32'h0);
  endtask

  task automatic t_rom;
    acc("R2", 32'hFF00_1ABC, 0, 2'd2, 1, 0, 32'h1357_9BDF, 0, 0, 1, 3'd1, 24'h00_0ABC, 4'hF, 0, 32'h1357_9BDF);
    acc("R6", 32'hFF00_0000, 1, 2'd2, 0, 32'h0000_1111, 0, 0, 0, 0, 3'd0, 0, 0, 0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_main_ram();
    t_io();
    t_wram();
    t_tcm();
    t_unmapped();
    t_rom();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule